// File: doc/BRIEF.md
# LCD Frame Header Decoder and Size Checker

This block runs once at the start of every frame that an LCD controller fetches. On a frame-start strobe it reads the depth code from the first 16-bit word of the frame buffer and the palette loading mode. From these it works out the pixel depth and the byte offset at which pixel data begins. It then checks that the whole image fits inside the DMA window of the buffer in use. If the image fits, the block reports the line range that remains after subpanel clipping and the byte offset of the first fetch. It also steps the buffer index between the first and second frame buffer when dual buffering is on. If the image does not fit, the block raises a sync error and stops the controller until software clears the enable.

A top state machine sequences the work through the states IDLE, AREA, CHECK, VERDICT, LINE and HALT. IDLE moves to AREA on an accepted start. A skipped start stays in IDLE. AREA moves to CHECK when the width-by-height product is ready. CHECK always moves to VERDICT. VERDICT moves to HALT on an overrun and to LINE otherwise. LINE returns to IDLE when the stride-by-start-line product is ready. HALT is left only through the enable. Clearing the enable sends every state to IDLE.

A second machine holds the buffer index in one of three states: IDLE_BUF (no frame since enable), FIRST and SECOND. IDLE_BUF moves to FIRST on an accepted start. On each accepted frame with dual mode on, FIRST and SECOND swap. Any state moves to IDLE_BUF while the enable is low. One serial shift-add multiplier is shared by both products.

Top module: `lcd_frame_hdr`

## Requirements
- R1: After reset, busy_o, done_o, skip_o, sync_err_o, frame_adv_o, halted_o and sel_valid_o are 0, and cond_o is 2'b00.
- R2: With palette mode 1 (palette only), a frame start processes no frame data. done_o and skip_o pulse together on the edge that samples the start. No frame_adv_o and no sync_err_o follow.
- R3: The depth code is hdr_word_i[14:12]. Code 1 reports bpp_o = 2, code 2 reports 4, code 3 reports 8, and codes 4 to 7 report 16. Code 0 (in any mode other than 1) sets bpp_o = 0 and the start is skipped as in R2.
- R4: data_off_o is 0 in palette mode 2 (no palette). In the other modes it is 0x200 when the depth code is 3 or above, and 0x20 otherwise.
- R5: color16_o is 1 only at 16 bpp with tft_i = 1. A passive panel (tft_i = 0) at 16 bpp reports 0, which selects 12-bit colour.
- R6: The required size is data_off + floor(width*height*bpp/8). When it exceeds window+2, the frame aborts: done_o and sync_err_o pulse, frame_adv_o does not pulse, and halted_o goes to 1. While halted, frame starts give no done_o. halted_o clears once enable_i is low. A size equal to window+2 is accepted.
- R7: The window is win1_size_i while the buffer index is idle or FIRST, and win2_size_i while it is SECOND.
- R8: An accepted frame pulses frame_adv_o once with cond_o one-hot for the buffer used: bit 0 for FIRST, bit 1 for SECOND. With dual_i = 1 the index then swaps. With dual_i = 0 it is kept.
- R9: If subpanel_i bit 31 is 0, start_line_o = 0 and end_line_o = height. If bit 31 is 1 and bit 29 is 1, start_line_o = subpanel_i[25:16] and end_line_o = height. If bit 31 is 1 and bit 29 is 0, start_line_o = 0 and end_line_o = subpanel_i[25:16].
- R10: fetch_off_o = data_off + stride*start_line, where stride = floor(width*bpp/8).
- R11: Let N be the multiplier operand width, DIM_W+1 (12 by default), and count edges from the edge that samples frame_start_i. A skip is reported on that edge. An overrun is reported N+3 edges later. An accepted frame pulses frame_adv_o N+3 edges later and done_o 2N+4 edges later.
- R12: While enable_i is low the buffer index returns to idle (sel_valid_o = 0). The first frame after enable_i rises uses FIRST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Controller enable; low aborts and idles |
| frame_start_i | input | 1 | Frame-start strobe, sampled in IDLE |
| plm_i | input | 2 | Palette loading mode (1 palette only, 2 no palette) |
| tft_i | input | 1 | Active-matrix panel flag |
| hdr_word_i | input | 16 | First 16-bit word of the frame buffer |
| width_i | input | DIM_W | Width in pixels |
| height_i | input | DIM_W | Height in lines |
| subpanel_i | input | 32 | Subpanel clipping word |
| dual_i | input | 1 | Dual frame buffer mode |
| win1_size_i | input | WIN_W | Window size of the first buffer in bytes |
| win2_size_i | input | WIN_W | Window size of the second buffer in bytes |
| busy_o | output | 1 | A frame is being checked |
| done_o | output | 1 | One-cycle pulse: frame handling complete |
| skip_o | output | 1 | One-cycle pulse: frame skipped |
| sync_err_o | output | 1 | One-cycle pulse: window overrun |
| frame_adv_o | output | 1 | One-cycle pulse: frame accepted |
| cond_o | output | 2 | One-hot buffer flag with frame_adv_o |
| halted_o | output | 1 | Controller stopped after an overrun |
| bpp_o | output | 5 | Bits per pixel |
| color16_o | output | 1 | 16-bit colour (1) or 12-bit colour (0) |
| data_off_o | output | 10 | Byte offset of pixel data |
| start_line_o | output | DIM_W | First line to fetch |
| end_line_o | output | DIM_W | Line bound (exclusive) |
| fetch_off_o | output | 2*DIM_W+3 | Byte offset of the first fetch |
| frame_sel_o | output | 1 | Current buffer: 0 first, 1 second |
| sel_valid_o | output | 1 | Buffer index is not idle |

## Verification
Results arrive at three fixed distances from the edge that samples the start strobe. A skip is reported on that edge. An overrun is reported N+3 edges later, together with the frame-advance pulse slot. A full acceptance is reported 2N+4 edges later. The driver stamps each expected item with the cycle count of the sampling edge. The monitor samples outputs on falling edges, and when done_o appears it compares the elapsed edges with the item's latency as well as every result field. The frame-advance pulse is captured when it occurs and is matched against the item at completion, so a pulse in a rejected or skipped frame is caught.

// File: rtl/lcd_hdr_pkg.sv
package lcd_hdr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_AREA,
        S_CHECK,
        S_VERDICT,
        S_LINE,
        S_HALT
    } hdr_state_t;

    typedef enum logic [1:0] {
        BUF_IDLE,
        BUF_FIRST,
        BUF_SECOND
    } buf_state_t;

    // palette loading modes
    localparam logic [1:0] PLM_PAL_ONLY = 2'd1;
    localparam logic [1:0] PLM_NO_PAL   = 2'd2;

    // header word field
    localparam int DEPTH_LSB = 12;

    // subpanel word fields
    localparam int SUB_EN_BIT    = 31;
    localparam int SUB_START_BIT = 29;
    localparam int SUB_LINE_LSB  = 16;
    localparam int SUB_LINE_W    = 10;

    // pixel data offsets
    localparam int OFF_W = 10;
    localparam logic [OFF_W-1:0] OFF_SHORT = 10'h020;
    localparam logic [OFF_W-1:0] OFF_LONG  = 10'h200;

endpackage

// File: rtl/lcd_hdr_decode.sv
module lcd_hdr_decode
    import lcd_hdr_pkg::*;
(
    input  logic [15:0]      hdr_word,
    input  logic [1:0]       plm,
    input  logic             tft,
    output logic             supported,
    output logic [2:0]       bpp_log2,
    output logic [4:0]       bpp,
    output logic [OFF_W-1:0] data_off,
    output logic             color16
);
    logic [2:0] code;

    always_comb begin
        code      = hdr_word[DEPTH_LSB +: 3];
        supported = 1'b1;
        unique case (code)
            3'd0:    begin bpp_log2 = 3'd0; supported = 1'b0; end
            3'd1:    bpp_log2 = 3'd1;
            3'd2:    bpp_log2 = 3'd2;
            3'd3:    bpp_log2 = 3'd3;
            default: bpp_log2 = 3'd4;
        endcase
        bpp = supported ? (5'd1 << bpp_log2) : 5'd0;
        if (plm == PLM_NO_PAL)
            data_off = '0;
        else if (code >= 3'd3)
            data_off = OFF_LONG;
        else
            data_off = OFF_SHORT;
        color16 = (bpp_log2 == 3'd4) && tft;
    end
endmodule

// File: rtl/lcd_seq_mul.sv
module lcd_seq_mul #(
    parameter  int OP_W   = 12,
    localparam int PROD_W = 2 * OP_W,
    localparam int CNT_W  = $clog2(OP_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   a,
    input  logic [OP_W-1:0]   b,
    output logic [PROD_W-1:0] prod,
    output logic              fin
);
    logic [PROD_W-1:0] mcand;
    logic [OP_W-1:0]   mplier;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prod   <= '0;
            mcand  <= '0;
            mplier <= '0;
            cnt    <= '0;
            fin    <= 1'b0;
        end else if (start) begin
            prod   <= '0;
            mcand  <= PROD_W'(a);
            mplier <= b;
            cnt    <= CNT_W'(OP_W);
            fin    <= 1'b0;
        end else if (cnt != '0) begin
            if (mplier[0])
                prod <= prod + mcand;
            mcand  <= mcand << 1;
            mplier <= mplier >> 1;
            cnt    <= cnt - CNT_W'(1);
            fin    <= (cnt == CNT_W'(1));
        end else begin
            fin <= 1'b0;
        end
    end

    // R11: the product-ready flag is a single-cycle pulse
    p_fin_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
endmodule

// File: rtl/lcd_buf_sel.sv
module lcd_buf_sel
    import lcd_hdr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dual,
    input  logic begin_fr,
    input  logic adv,
    output logic sel_second,
    output logic sel_valid
);
    buf_state_t st, st_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= BUF_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        if (!enable) begin
            st_nxt = BUF_IDLE;
        end else begin
            unique case (st)
                BUF_IDLE:   if (begin_fr)    st_nxt = BUF_FIRST;
                BUF_FIRST:  if (adv && dual) st_nxt = BUF_SECOND;
                BUF_SECOND: if (adv && dual) st_nxt = BUF_FIRST;
                default:    st_nxt = BUF_IDLE;
            endcase
        end
    end

    always_comb begin
        sel_second = (st == BUF_SECOND);
        sel_valid  = (st != BUF_IDLE);
    end

    // R12: a low enable idles the buffer index
    p_idle_on_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sel_valid);

    // R8: dual mode swaps the buffer after an accepted frame
    p_dual_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && dual && enable && sel_valid) |=> (sel_second != $past(sel_second)));
endmodule

// File: rtl/lcd_frame_hdr.sv
module lcd_frame_hdr
    import lcd_hdr_pkg::*;
#(
    parameter  int DIM_W   = 11,
    parameter  int WIN_W   = 24,
    localparam int MUL_W   = DIM_W + 1,
    localparam int PROD_W  = 2 * MUL_W,
    localparam int FETCH_W = PROD_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic               frame_start_i,
    input  logic [1:0]         plm_i,
    input  logic               tft_i,
    input  logic [15:0]        hdr_word_i,
    input  logic [DIM_W-1:0]   width_i,
    input  logic [DIM_W-1:0]   height_i,
    input  logic [31:0]        subpanel_i,
    input  logic               dual_i,
    input  logic [WIN_W-1:0]   win1_size_i,
    input  logic [WIN_W-1:0]   win2_size_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               skip_o,
    output logic               sync_err_o,
    output logic               frame_adv_o,
    output logic [1:0]         cond_o,
    output logic               halted_o,
    output logic [4:0]         bpp_o,
    output logic               color16_o,
    output logic [OFF_W-1:0]   data_off_o,
    output logic [DIM_W-1:0]   start_line_o,
    output logic [DIM_W-1:0]   end_line_o,
    output logic [FETCH_W-1:0] fetch_off_o,
    output logic               frame_sel_o,
    output logic               sel_valid_o
);
    localparam int NEED_W = PROD_W + 2;
    localparam int CMP_W  = (NEED_W > WIN_W + 2) ? NEED_W : WIN_W + 2;

    hdr_state_t state, state_nxt;

    // decode of the live inputs
    logic             dec_sup, dec_c16;
    logic [2:0]       dec_log;
    logic [4:0]       dec_bpp;
    logic [OFF_W-1:0] dec_off;

    lcd_hdr_decode u_decode (
        .hdr_word  (hdr_word_i),
        .plm       (plm_i),
        .tft       (tft_i),
        .supported (dec_sup),
        .bpp_log2  (dec_log),
        .bpp       (dec_bpp),
        .data_off  (dec_off),
        .color16   (dec_c16)
    );

    // frame-scoped registers
    logic [2:0]       log_q;
    logic [MUL_W-1:0] stride_q;
    logic [WIN_W-1:0] win_q;
    logic [CMP_W-1:0] need_q;
    logic             err_q;

    // control decisions
    logic skip_now, take, begin_fr, accept;
    logic sel_second, sel_valid;

    always_comb begin
        skip_now = (plm_i == PLM_PAL_ONLY) || !dec_sup;
        take     = (state == S_IDLE) && enable_i && frame_start_i;
        begin_fr = take && !skip_now;
        accept   = (state == S_VERDICT) && enable_i && !err_q;
    end

    // shared multiplier: width*height first, then stride*start line
    logic [MUL_W-1:0]  mul_a, mul_b;
    logic [PROD_W-1:0] mul_prod;
    logic              mul_fin, mul_start;

    always_comb begin
        mul_start = begin_fr || accept;
        if (state == S_IDLE) begin
            mul_a = MUL_W'(width_i);
            mul_b = MUL_W'(height_i);
        end else begin
            mul_a = stride_q;
            mul_b = MUL_W'(start_line_o);
        end
    end

    lcd_seq_mul #(.OP_W(MUL_W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .a     (mul_a),
        .b     (mul_b),
        .prod  (mul_prod),
        .fin   (mul_fin)
    );

    lcd_buf_sel u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable_i),
        .dual       (dual_i),
        .begin_fr   (begin_fr),
        .adv        (accept),
        .sel_second (sel_second),
        .sel_valid  (sel_valid)
    );

    // subpanel clipping and stride for the live inputs
    logic              sub_on, sub_start;
    logic [DIM_W-1:0]  sub_line;
    logic [DIM_W-1:0]  sl_next, el_next;
    logic [MUL_W+3:0]  wid_sh;
    logic [MUL_W-1:0]  stride_next;

    always_comb begin
        sub_on      = subpanel_i[SUB_EN_BIT];
        sub_start   = subpanel_i[SUB_START_BIT];
        sub_line    = DIM_W'(subpanel_i[SUB_LINE_LSB +: SUB_LINE_W]);
        sl_next     = (sub_on && sub_start)  ? sub_line : '0;
        el_next     = (sub_on && !sub_start) ? sub_line : height_i;
        wid_sh      = (MUL_W+4)'(width_i) << dec_log;
        stride_next = wid_sh[MUL_W+2:3];
    end

    // byte count of the whole image from the area product
    logic [PROD_W+3:0] area_sh;
    logic [CMP_W-1:0]  need_next, limit;

    always_comb begin
        area_sh   = (PROD_W+4)'(mul_prod) << log_q;
        need_next = CMP_W'(area_sh[PROD_W+3:3]) + CMP_W'(data_off_o);
        limit     = CMP_W'(win_q) + CMP_W'(2);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (!enable_i) begin
            state_nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:    if (frame_start_i && !skip_now) state_nxt = S_AREA;
                S_AREA:    if (mul_fin) state_nxt = S_CHECK;
                S_CHECK:   state_nxt = S_VERDICT;
                S_VERDICT: state_nxt = err_q ? S_HALT : S_LINE;
                S_LINE:    if (mul_fin) state_nxt = S_IDLE;
                S_HALT:    state_nxt = S_HALT;
                default:   state_nxt = S_IDLE;
            endcase
        end
    end

    // outputs and frame registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o       <= 1'b0;
            skip_o       <= 1'b0;
            sync_err_o   <= 1'b0;
            frame_adv_o  <= 1'b0;
            cond_o       <= '0;
            bpp_o        <= '0;
            color16_o    <= 1'b0;
            data_off_o   <= '0;
            start_line_o <= '0;
            end_line_o   <= '0;
            fetch_off_o  <= '0;
            log_q        <= '0;
            stride_q     <= '0;
            win_q        <= '0;
            need_q       <= '0;
            err_q        <= 1'b0;
        end else begin
            done_o      <= 1'b0;
            skip_o      <= 1'b0;
            sync_err_o  <= 1'b0;
            frame_adv_o <= 1'b0;
            cond_o      <= '0;
            if (take) begin
                bpp_o        <= dec_bpp;
                color16_o    <= dec_c16;
                data_off_o   <= dec_off;
                start_line_o <= sl_next;
                end_line_o   <= el_next;
                log_q        <= dec_log;
                stride_q     <= stride_next;
                win_q        <= sel_second ? win2_size_i : win1_size_i;
                err_q        <= 1'b0;
                if (skip_now) begin
                    done_o <= 1'b1;
                    skip_o <= 1'b1;
                end
            end
            if (enable_i && state == S_AREA && mul_fin)
                need_q <= need_next;
            if (enable_i && state == S_CHECK)
                err_q <= (need_q > limit);
            if (enable_i && state == S_VERDICT) begin
                if (err_q) begin
                    done_o     <= 1'b1;
                    sync_err_o <= 1'b1;
                end else begin
                    frame_adv_o <= 1'b1;
                    cond_o      <= sel_second ? 2'b10 : 2'b01;
                end
            end
            if (enable_i && state == S_LINE && mul_fin) begin
                fetch_off_o <= FETCH_W'(mul_prod) + FETCH_W'(data_off_o);
                done_o      <= 1'b1;
            end
        end
    end

    always_comb begin
        busy_o      = (state != S_IDLE) && (state != S_HALT);
        halted_o    = (state == S_HALT);
        frame_sel_o = sel_second;
        sel_valid_o = sel_valid;
    end

    // R2: a skip always completes the frame
    p_skip_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> (done_o && !sync_err_o && !frame_adv_o));

    // R6: an overrun completes the frame and stops the controller
    p_err_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err_o |-> (halted_o && done_o && !frame_adv_o));

    // R6: no completion while stopped
    p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && enable_i) |=> !done_o);

    // R8: acceptance flags exactly one buffer
    p_adv_cond_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_adv_o |-> ($countones(cond_o) == 1));

    // R8: no buffer flag without acceptance
    p_cond_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_adv_o |-> (cond_o == 2'b00));
endmodule

// File: tb/lcd_frame_hdr_test.sv
module lcd_frame_hdr_test;
    localparam int DIM_W = 11;
    localparam int WIN_W = 24;
    localparam int N     = DIM_W + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable_i = 1'b0;
    logic              frame_start_i = 1'b0;
    logic [1:0]        plm_i = '0;
    logic              tft_i = 1'b0;
    logic [15:0]       hdr_word_i = '0;
    logic [DIM_W-1:0]  width_i = '0;
    logic [DIM_W-1:0]  height_i = '0;
    logic [31:0]       subpanel_i = '0;
    logic              dual_i = 1'b0;
    logic [WIN_W-1:0]  win1_size_i = '0;
    logic [WIN_W-1:0]  win2_size_i = '0;
    logic              busy_o, done_o, skip_o, sync_err_o, frame_adv_o;
    logic [1:0]        cond_o;
    logic              halted_o, color16_o, frame_sel_o, sel_valid_o;
    logic [4:0]        bpp_o;
    logic [9:0]        data_off_o;
    logic [DIM_W-1:0]  start_line_o, end_line_o;
    logic [2*N:0]      fetch_off_o;

    lcd_frame_hdr #(.DIM_W(DIM_W), .WIN_W(WIN_W)) uut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .frame_start_i(frame_start_i),
        .plm_i(plm_i), .tft_i(tft_i), .hdr_word_i(hdr_word_i), .width_i(width_i),
        .height_i(height_i), .subpanel_i(subpanel_i), .dual_i(dual_i),
        .win1_size_i(win1_size_i), .win2_size_i(win2_size_i), .busy_o(busy_o),
        .done_o(done_o), .skip_o(skip_o), .sync_err_o(sync_err_o),
        .frame_adv_o(frame_adv_o), .cond_o(cond_o), .halted_o(halted_o),
        .bpp_o(bpp_o), .color16_o(color16_o), .data_off_o(data_off_o),
        .start_line_o(start_line_o), .end_line_o(end_line_o),
        .fetch_off_o(fetch_off_o), .frame_sel_o(frame_sel_o), .sel_valid_o(sel_valid_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        int     kind;   // 0 skip, 1 overrun, 2 accepted
        string  tag;
        int     bpp;
        int     c16;
        int     off;
        int     sl;
        int     el;
        longint fetch;
        int     cond;
        int     lat;
        longint t0;
    } exp_t;

    exp_t   exp_q[$];
    int     n_checks = 0;
    int     n_fail = 0;
    longint cyc = 0;
    int     bidx = 0;   // 0 idle, 1 first, 2 second
    bit     adv_seen = 0;
    int     adv_cond = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor: compare completions against the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (frame_adv_o) begin
                adv_seen = 1'b1;
                adv_cond = int'(cond_o);
            end
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(cyc - e.t0 == e.lat, "R11", "latency", cyc - e.t0, e.lat);
                    chk(int'(skip_o) == (e.kind == 0), e.tag, "skip", skip_o, e.kind == 0);
                    chk(int'(sync_err_o) == (e.kind == 1), e.tag, "sync error",
                        sync_err_o, e.kind == 1);
                    chk(int'(adv_seen) == (e.kind == 2), "R8", "advance seen",
                        adv_seen, e.kind == 2);
                    chk(int'(bpp_o) == e.bpp, "R3", "bpp", bpp_o, e.bpp);
                    if (e.kind != 0) begin
                        chk(int'(color16_o) == e.c16, "R5", "color16", color16_o, e.c16);
                        chk(int'(data_off_o) == e.off, "R4", "data offset", data_off_o, e.off);
                        chk(int'(start_line_o) == e.sl, "R9", "start line", start_line_o, e.sl);
                        chk(int'(end_line_o) == e.el, "R9", "end line", end_line_o, e.el);
                    end
                    if (e.kind == 1)
                        chk(halted_o == 1'b1, "R6", "halted", halted_o, 1);
                    if (e.kind == 2) begin
                        chk(longint'(fetch_off_o) == e.fetch, "R10", "fetch offset",
                            fetch_off_o, e.fetch);
                        chk(adv_cond == e.cond, "R8", "cond", adv_cond, e.cond);
                    end
                    adv_seen = 1'b0;
                end
            end
        end
    end

    task automatic run_frame(input string tag, input int plm, input int tft, input int code,
                             input int w, input int h, input int sub);
        exp_t   e;
        int     bpp, lg;
        longint need, win;
        @(negedge clk);
        plm_i      = 2'(plm);
        tft_i      = tft[0];
        hdr_word_i = {1'b0, 3'(code), 12'h5A3};
        width_i    = DIM_W'(w);
        height_i   = DIM_W'(h);
        subpanel_i = sub;
        e.tag = tag;
        case (code)
            0: begin bpp = 0; lg = 0; end
            1: begin bpp = 2; lg = 1; end
            2: begin bpp = 4; lg = 2; end
            3: begin bpp = 8; lg = 3; end
            default: begin bpp = 16; lg = 4; end
        endcase
        e.bpp  = bpp;
        e.c16  = (bpp == 16 && tft != 0) ? 1 : 0;
        e.off  = (plm == 2) ? 0 : ((code >= 3) ? 'h200 : 'h20);
        e.sl   = (sub[31] && sub[29])  ? ((sub >> 16) & 'h3ff) : 0;
        e.el   = (sub[31] && !sub[29]) ? ((sub >> 16) & 'h3ff) : h;
        e.fetch = e.off + ((longint'(w) * bpp) / 8) * e.sl;
        e.cond = 0;
        if (plm == 1 || code == 0) begin
            e.kind = 0;
            e.lat  = 0;
        end else begin
            if (bidx == 0) bidx = 1;
            win  = (bidx == 2) ? longint'(win2_size_i) : longint'(win1_size_i);
            need = e.off + (longint'(w) * h * bpp) / 8;
            if (need > win + 2) begin
                e.kind = 1;
                e.lat  = N + 3;
            end else begin
                e.kind = 2;
                e.lat  = 2 * N + 4;
                e.cond = (bidx == 2) ? 2 : 1;
                if (dual_i) bidx = (bidx == 1) ? 2 : 1;
            end
        end
        frame_start_i = 1'b1;
        e.t0 = cyc + 1;
        exp_q.push_back(e);
        @(negedge clk);
        frame_start_i = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic toggle_enable();
        @(negedge clk);
        enable_i = 1'b0;
        bidx = 0;
        repeat (2) @(negedge clk);
        chk(halted_o == 1'b0, "R6", "halt cleared", halted_o, 0);
        chk(sel_valid_o == 1'b0, "R12", "buffer idle", sel_valid_o, 0);
        enable_i = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R11", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        win1_size_i = 24'hFFFFF;
        win2_size_i = 24'hFFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy_o == 0 && done_o == 0 && skip_o == 0, "R1", "idle pulses",
            {busy_o, done_o, skip_o}, 0);
        chk(sync_err_o == 0 && frame_adv_o == 0 && cond_o == 0, "R1", "error/advance",
            {sync_err_o, frame_adv_o, cond_o}, 0);
        chk(halted_o == 0 && sel_valid_o == 0, "R1", "halt/buffer",
            {halted_o, sel_valid_o}, 0);
        enable_i = 1'b1;

        run_frame("R2", 1, 0, 3, 64, 32, 0);                              // palette only
        run_frame("R3", 0, 0, 0, 64, 32, 0);                              // depth code 0
        run_frame("R3", 0, 0, 1, 100, 50, 0);                             // 2 bpp
        run_frame("R9", 0, 0, 3, 64, 32, (1 << 31) | (1 << 29) | (10 << 16)); // start clip
        run_frame("R5", 2, 1, 5, 40, 30, (1 << 31) | (20 << 16));        // end clip, TFT
        run_frame("R5", 3, 0, 7, 8, 8, 0);                                // passive 16 bpp
        run_frame("R10", 0, 0, 2, 33, 3, (1 << 31) | (1 << 29) | (2 << 16)); // odd stride

        // R6 boundary: 0x200 + 256 = 768 bytes
        win1_size_i = 24'd766;
        run_frame("R6", 0, 0, 3, 16, 16, 0);
        win1_size_i = 24'd765;
        run_frame("R6", 0, 0, 3, 16, 16, 0);
        // R6: start ignored while halted
        @(negedge clk);
        frame_start_i = 1'b1;
        @(negedge clk);
        frame_start_i = 1'b0;
        repeat (40) @(negedge clk);
        chk(halted_o == 1'b1, "R6", "still halted", halted_o, 1);
        toggle_enable();

        // R7/R8 dual buffering
        win1_size_i = 24'hFFFFF;
        dual_i = 1'b1;
        run_frame("R8", 0, 0, 3, 32, 8, 0);
        chk(frame_sel_o == 1'b1, "R8", "swapped to second", frame_sel_o, 1);
        run_frame("R8", 0, 0, 3, 32, 8, 0);
        run_frame("R8", 0, 0, 3, 32, 8, 0);
        win2_size_i = 24'd100;
        run_frame("R7", 0, 0, 3, 32, 8, 0);                               // second window too small
        toggle_enable();
        run_frame("R12", 0, 0, 3, 32, 8, 0);                              // back on first
        dual_i = 1'b0;
        run_frame("R8", 0, 0, 1, 32, 8, 0);                               // single: stays
        chk(frame_sel_o == 1'b1, "R8", "single keeps buffer", frame_sel_o, 1);

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule